// File: doc/BRIEF.md
# SD Host Slot Hub Register Block

This block is the shared register front end that sits before one or two SD host slot controllers. A host issues 32-bit word requests on a valid/ready port. Requests that land in the global page (byte offsets 0x000 to 0x0FF) are served locally. These local registers cover a control/info word, a debounce word, a bus setting word, a write-protect polarity word, a card-detect word, an interrupt status word and, for each present slot, a 64-bit capability value and a maximum-current word. Requests that land in the 256-byte window of a present slot are passed on to that slot's request port, and the slot's answer is returned to the host.

The capability value is 64 bits wide and is reached through two 32-bit words. Each word can be written on its own. Its reset value is a parameter, so one design can serve several chip variants. Each slot drives a level interrupt line into the block. The block keeps those lines in its status word and merges them into one interrupt output.

Top module: `sdhub_regs`

## Requirements
- R1: After reset the words read: 0x000 = bit 16 set, plus bit 17 when NUM_SLOTS is 2; 0x004 = DEB_RESET (default 0x00000005); 0x008, 0x0EC, 0x0F0 and 0x0FC = 0; capability of slot s = CAP_RESET; maximum-current of slot s = 0; irq_out = 0.
- R2: A write to 0x000 stores bits 31..1 of the data. Bit 0 is a self-clearing request and always reads back 0.
- R3: The words at 0x004, 0x008, 0x0EC and 0x0F0 store all 32 written bits and read them back.
- R4: Slot s (s = 0 or 1) has its capability low word at 0x010+0x10*s, its high word at 0x014+0x10*s and its maximum-current word at 0x018+0x10*s. A write changes only the addressed 32-bit word.
- R5: An offset in the global page that maps to no register, including the capability group of an absent slot, reads 0 and ignores writes. The same holds for a window (i+1)*0x100 with i >= NUM_SLOTS, which is never forwarded.
- R6: A request with req_strb other than 4'b1111 or with req_addr[1:0] other than 0 is served locally. Such a request reads 0, writes nothing and is never forwarded.
- R7: When slot_irq[n] rises, bit n of 0x0FC is set from the next cycle on. When it falls, bit n is cleared from the next cycle on. Writes to 0x0FC are ignored.
- R8: irq_out is 1 exactly in the cycles in which some bit of 0x0FC is set.
- R9: A local request is always ready when no slot request is outstanding. rsp_valid is high for exactly the one cycle after acceptance, with read data, or 0 for a write.
- R10: A request to offset (i+1)*0x100+k, with i < NUM_SLOTS, raises slot_req_valid[i] with slot_req_addr = k and the request's write flag and data. req_ready follows slot_req_ready[i]. The slot's slot_rsp_valid[i] and its data appear on rsp_valid/rsp_rdata in the same cycle.
- R11: While a forwarded request awaits its slot response, req_ready is 0 for every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KiB block |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte lanes; only 4'b1111 is a valid access |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Response data |
| slot_req_valid | output | NUM_SLOTS | Forwarded request valid, one bit per slot |
| slot_req_ready | input | NUM_SLOTS | Slot accepts forwarded request |
| slot_req_write | output | 1 | Forwarded write flag |
| slot_req_addr | output | 8 | Byte offset inside the slot window |
| slot_req_wdata | output | 32 | Forwarded write data |
| slot_rsp_valid | input | NUM_SLOTS | Slot response valid |
| slot_rsp_rdata | input | 32*NUM_SLOTS | Slot response data, slot s at bits 32*s+31..32*s |
| slot_irq | input | NUM_SLOTS | Level interrupt from each slot |
| irq_out | output | 1 | Merged interrupt |

## Verification
The bench builds the block twice. The main instance has two slots and capability reset 0x0000000701F80080. A second instance has one slot and capability reset 0x0000000001E80080. With two slots, the second slot's forwarding, its capability group and info bit 17 can be reached. With one slot, the absent-slot cases can be reached: bit 17 stays clear, the 0x020 group reads zero and window 0x200 stays local. The two instances also load two different capability reset values. A slot responder model in the bench with adjustable ready and latency exercises backpressure and the single-outstanding rule. A per-cycle interrupt model follows the irq lines.

// File: rtl/sdhub_pkg.sv
package sdhub_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int WIN_W  = 8;
  localparam int CAP_W  = 2 * DATA_W;
  localparam int GRP_W  = ADDR_W - WIN_W;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_INFO, SEL_DEB, SEL_BUS, SEL_WPP, SEL_CDET, SEL_ISTAT,
    SEL_CAPLO, SEL_CAPHI, SEL_MAXC, SEL_WIN
  } sel_e;

  typedef struct packed {
    sel_e             sel;
    logic [GRP_W-1:0] grp;
  } dec_t;

  // presence bits start at 16, one per slot
  function automatic logic [DATA_W-1:0] info_at_reset(input int nslot);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < nslot; i++) v[16+i] = 1'b1;
    return v;
  endfunction

  // the request bit never stays set
  function automatic logic [DATA_W-1:0] info_keep(input logic [DATA_W-1:0] w);
    return {w[DATA_W-1:1], 1'b0};
  endfunction

  function automatic logic [CAP_W-1:0] put_half(input logic [CAP_W-1:0] old,
                                                input logic hi,
                                                input logic [DATA_W-1:0] w);
    return hi ? {w, old[DATA_W-1:0]} : {old[CAP_W-1:DATA_W], w};
  endfunction

  function automatic logic is_word(input logic [ADDR_W-1:0] a,
                                   input logic [STRB_W-1:0] s);
    return (s == {STRB_W{1'b1}}) && (a[1:0] == 2'b00);
  endfunction

  function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                  input logic [STRB_W-1:0] s,
                                  input int nslot);
    dec_t             d;
    logic [GRP_W-1:0] hi;
    logic [WIN_W-1:0] lo;
    logic [3:0]       grp_lo;
    d.sel  = SEL_NONE;
    d.grp  = '0;
    hi     = a[ADDR_W-1:WIN_W];
    lo     = a[WIN_W-1:0];
    grp_lo = lo[7:4];
    if (is_word(a, s)) begin
      if (hi != '0) begin
        if (int'(hi) <= nslot) begin
          d.sel = SEL_WIN;
          d.grp = hi - GRP_W'(1);
        end
      end else begin
        case (lo)
          8'h00:   d.sel = SEL_INFO;
          8'h04:   d.sel = SEL_DEB;
          8'h08:   d.sel = SEL_BUS;
          8'hEC:   d.sel = SEL_WPP;
          8'hF0:   d.sel = SEL_CDET;
          8'hFC:   d.sel = SEL_ISTAT;
          default: begin
            if (int'(grp_lo) >= 1 && int'(grp_lo) <= nslot) begin
              d.grp = GRP_W'(grp_lo - 4'd1);
              case (lo[3:0])
                4'h0:    d.sel = SEL_CAPLO;
                4'h4:    d.sel = SEL_CAPHI;
                4'h8:    d.sel = SEL_MAXC;
                default: d.sel = SEL_NONE;
              endcase
            end
          end
        endcase
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/sdhub_decode.sv
module sdhub_decode import sdhub_pkg::*; #(
  parameter int NUM_SLOTS = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [STRB_W-1:0]    strb,
  output dec_t                 dec,
  output logic                 is_win,
  output logic [NUM_SLOTS-1:0] win_hot
);
  assign dec    = decode(addr, strb, NUM_SLOTS);
  assign is_win = (dec.sel == SEL_WIN);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hot
    assign win_hot[i] = is_win && (dec.grp == GRP_W'(i));
  end
endmodule

// File: rtl/sdhub_glob_regs.sv
module sdhub_glob_regs import sdhub_pkg::*; #(
  parameter int                NUM_SLOTS = 2,
  parameter logic [DATA_W-1:0] DEB_RESET = 32'h0000_0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] istat,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] INFO_RST = info_at_reset(NUM_SLOTS);

  logic [DATA_W-1:0] info_q, deb_q, bus_q, wpp_q, cdet_q;
  logic              info_wr;

  assign info_wr = wr_en && (sel == SEL_INFO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= INFO_RST;
      deb_q  <= DEB_RESET;
      bus_q  <= '0;
      wpp_q  <= '0;
      cdet_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_INFO: info_q <= info_keep(wdata);
        SEL_DEB:  deb_q  <= wdata;
        SEL_BUS:  bus_q  <= wdata;
        SEL_WPP:  wpp_q  <= wdata;
        SEL_CDET: cdet_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_INFO:  rdata = info_q;
      SEL_DEB:   rdata = deb_q;
      SEL_BUS:   rdata = bus_q;
      SEL_WPP:   rdata = wpp_q;
      SEL_CDET:  rdata = cdet_q;
      SEL_ISTAT: rdata = istat;
      default:   rdata = '0;
    endcase
  end

  // R2: stored upper bits follow the write, bit 0 never holds
  p_info_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    info_wr |=> (info_q[0] == 1'b0) && (info_q[DATA_W-1:1] == $past(wdata[DATA_W-1:1])));

  // R3: a write elsewhere leaves the bus word untouched
  p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel != SEL_BUS) |=> $stable(bus_q));
endmodule

// File: rtl/sdhub_slot_caps.sv
module sdhub_slot_caps import sdhub_pkg::*; #(
  parameter int               NUM_SLOTS = 2,
  parameter logic [CAP_W-1:0] CAP_RESET = 64'h0000_0007_01F8_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [GRP_W-1:0]  grp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] part [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [CAP_W-1:0]  cap_q;
    logic [DATA_W-1:0] maxc_q;
    logic              hit, wr_lo, wr_hi;

    assign hit   = (grp == GRP_W'(g));
    assign wr_lo = wr_en && hit && (sel == SEL_CAPLO);
    assign wr_hi = wr_en && hit && (sel == SEL_CAPHI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q  <= CAP_RESET;
        maxc_q <= '0;
      end else begin
        if (wr_lo || wr_hi) cap_q <= put_half(cap_q, wr_hi, wdata);
        if (wr_en && hit && sel == SEL_MAXC) maxc_q <= wdata;
      end
    end

    always_comb begin
      part[g] = '0;
      if (hit) begin
        case (sel)
          SEL_CAPLO: part[g] = cap_q[DATA_W-1:0];
          SEL_CAPHI: part[g] = cap_q[CAP_W-1:DATA_W];
          SEL_MAXC:  part[g] = maxc_q;
          default:   part[g] = '0;
        endcase
      end
    end

    // R4: a low-word write keeps the high word, and the reverse
    p_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> $stable(cap_q[CAP_W-1:DATA_W]));
    p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> $stable(cap_q[DATA_W-1:0]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) rdata |= part[i];
  end
endmodule

// File: rtl/sdhub_irq_collect.sv
module sdhub_irq_collect #(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] irq_in,
  output logic [NUM_SLOTS-1:0] stat,
  output logic                 irq_out
);
  logic [NUM_SLOTS-1:0] prev_q, stat_q, rise, fall;

  assign rise = irq_in & ~prev_q;
  assign fall = ~irq_in & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= irq_in;
      stat_q <= (stat_q | rise) & ~fall;
    end
  end

  assign stat    = stat_q;
  assign irq_out = |stat_q;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_chk
    p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rise[n] |=> stat[n]);
    p_fall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fall[n] |=> !stat[n]);
  end

  p_irq_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|rise));
  p_irq_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(|fall));
endmodule

// File: rtl/sdhub_regs.sv
module sdhub_regs import sdhub_pkg::*; #(
  parameter int                NUM_SLOTS = 2,
  parameter logic [CAP_W-1:0]  CAP_RESET = 64'h0000_0007_01F8_0080,
  parameter logic [DATA_W-1:0] DEB_RESET = 32'h0000_0005
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic [STRB_W-1:0]           req_strb,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [NUM_SLOTS-1:0]        slot_req_valid,
  input  logic [NUM_SLOTS-1:0]        slot_req_ready,
  output logic                        slot_req_write,
  output logic [WIN_W-1:0]            slot_req_addr,
  output logic [DATA_W-1:0]           slot_req_wdata,
  input  logic [NUM_SLOTS-1:0]        slot_rsp_valid,
  input  logic [NUM_SLOTS*DATA_W-1:0] slot_rsp_rdata,
  input  logic [NUM_SLOTS-1:0]        slot_irq,
  output logic                        irq_out
);
  dec_t                 dec;
  logic                 is_win;
  logic [NUM_SLOTS-1:0] win_hot, pend_hot_q, irq_stat;
  logic                 pend_any, loc_accept, win_accept, slot_done, loc_wr;
  logic                 rsp_q;
  logic [DATA_W-1:0]    rsp_data_q, glob_rd, cap_rd, slot_data;

  sdhub_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr(req_addr), .strb(req_strb), .dec(dec), .is_win(is_win), .win_hot(win_hot)
  );

  assign pend_any   = |pend_hot_q;
  assign req_ready  = !pend_any && (is_win ? |(win_hot & slot_req_ready) : 1'b1);
  assign loc_accept = req_valid && req_ready && !is_win;
  assign win_accept = req_valid && req_ready && is_win;
  assign loc_wr     = loc_accept && req_write;
  assign slot_done  = |(pend_hot_q & slot_rsp_valid);

  assign slot_req_valid = {NUM_SLOTS{req_valid && !pend_any}} & win_hot;
  assign slot_req_write = req_write;
  assign slot_req_addr  = req_addr[WIN_W-1:0];
  assign slot_req_wdata = req_wdata;

  sdhub_irq_collect #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(slot_irq), .stat(irq_stat), .irq_out(irq_out)
  );

  sdhub_glob_regs #(.NUM_SLOTS(NUM_SLOTS), .DEB_RESET(DEB_RESET)) u_glob (
    .clk(clk), .rst_n(rst_n), .wr_en(loc_wr), .sel(dec.sel), .wdata(req_wdata),
    .istat(DATA_W'(irq_stat)), .rdata(glob_rd)
  );

  sdhub_slot_caps #(.NUM_SLOTS(NUM_SLOTS), .CAP_RESET(CAP_RESET)) u_caps (
    .clk(clk), .rst_n(rst_n), .wr_en(loc_wr), .sel(dec.sel), .grp(dec.grp),
    .wdata(req_wdata), .rdata(cap_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
      pend_hot_q <= '0;
    end else begin
      rsp_q <= loc_accept;
      if (loc_accept) rsp_data_q <= req_write ? '0 : (glob_rd | cap_rd);
      if (win_accept)     pend_hot_q <= win_hot;
      else if (slot_done) pend_hot_q <= '0;
    end
  end

  always_comb begin
    slot_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (pend_hot_q[i]) slot_data |= slot_rsp_rdata[i*DATA_W +: DATA_W];
  end

  assign rsp_valid = rsp_q || slot_done;
  assign rsp_rdata = slot_done ? slot_data : rsp_data_q;

  p_local_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_accept |=> rsp_valid);
  p_rsp_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_q && pend_any));
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> !req_ready);
  p_fwd_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_req_valid & slot_req_ready)) |=> pend_any);
  p_no_fwd_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_word(req_addr, req_strb)) |-> (slot_req_valid == '0));
  p_onehot_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_hot_q));
endmodule

// File: tb/sdhub_regs_bench.sv
module sdhub_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  // main instance, two slots
  logic        req_valid = 0, req_write = 0, req_ready, rsp_valid, slot_req_write, irq_out;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata, slot_req_wdata;
  logic [3:0]  req_strb = 4'hF;
  logic [1:0]  slot_req_valid, s_ready = 2'b11, s_rsp_v = 2'b00, slot_irq = 2'b00;
  logic [7:0]  slot_req_addr;
  logic [63:0] s_rsp_d = 64'h0;

  sdhub_regs u_sdhub_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slot_req_valid(slot_req_valid),
    .slot_req_ready(s_ready), .slot_req_write(slot_req_write), .slot_req_addr(slot_req_addr),
    .slot_req_wdata(slot_req_wdata), .slot_rsp_valid(s_rsp_v), .slot_rsp_rdata(s_rsp_d),
    .slot_irq(slot_irq), .irq_out(irq_out)
  );

  // one-slot instance
  logic        b_valid = 0, b_ready, b_rsp_valid, b_slot_write, b_irq;
  logic [11:0] b_addr = 0;
  logic [31:0] b_rdata, b_slot_wdata;
  logic [0:0]  b_slot_valid;
  logic [7:0]  b_slot_addr;
  int          b_fwd = 0;

  sdhub_regs #(.NUM_SLOTS(1), .CAP_RESET(64'h0000_0000_01E8_0080)) u_single (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_write(1'b0), .req_addr(b_addr), .req_wdata(32'h0), .req_strb(4'hF),
    .rsp_valid(b_rsp_valid), .rsp_rdata(b_rdata), .slot_req_valid(b_slot_valid),
    .slot_req_ready(1'b1), .slot_req_write(b_slot_write), .slot_req_addr(b_slot_addr),
    .slot_req_wdata(b_slot_wdata), .slot_rsp_valid(1'b0), .slot_rsp_rdata(32'h0),
    .slot_irq(1'b0), .irq_out(b_irq)
  );

  // slot responder model
  int         s_cnt [2] = '{0, 0};
  int         s_hits[2] = '{0, 0};
  logic [7:0] s_addr[2];
  logic       s_wr  [2];
  logic [31:0] s_wd [2];
  int         s_lat = 3;

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++)
      if (rst_n && slot_req_valid[i] && s_ready[i]) begin
        s_hits[i]++;
        s_addr[i] = slot_req_addr;
        s_wr[i]   = slot_req_write;
        s_wd[i]   = slot_req_wdata;
        s_cnt[i]  = s_lat;
      end
    if (rst_n && b_slot_valid[0]) b_fwd++;
  end

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (s_cnt[i] == 1) begin
        s_rsp_v[i] = 1'b1;
        s_rsp_d[i*32 +: 32] = 32'h5A00_0000 | (i << 16) | 32'(s_addr[i]);
        s_cnt[i] = 0;
      end else begin
        s_rsp_v[i] = 1'b0;
        if (s_cnt[i] > 1) s_cnt[i]--;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle interrupt reference: status equals the previous cycle's lines
  logic [1:0] m_stat = 2'b00;
  always @(posedge clk) m_stat = rst_n ? slot_irq : 2'b00;
  always @(negedge clk) begin
    #3;
    if (rst_n) chk("R8 irq_out per cycle", {31'b0, irq_out}, {31'b0, m_stat != 2'b00});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] rd, output int lat);
    int guard;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
    #2; guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); #2; guard++; end
    @(negedge clk);
    req_valid = 0;
    #2; lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); #2; lat++; end
    rd = rsp_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd; int lat;
    xfer(1'b0, a, 32'h0, 4'hF, rd, lat);
    chk(tag, rd, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; int lat;
    xfer(1'b1, a, d, 4'hF, rd, lat);
  endtask

  task automatic b_rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); b_valid = 1; b_addr = a;
    @(negedge clk); b_valid = 0; #2;
    chk({tag, " valid"}, {31'b0, b_rsp_valid}, 32'd1);
    chk(tag, b_rdata, exp);
  endtask

  initial begin
    logic [31:0] rd; int lat, hits0, hits1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1 irq_out", {31'b0, irq_out}, 32'd0);
    rd_chk("R1 info two slots", 12'h000, 32'h0003_0000);
    rd_chk("R1 debounce", 12'h004, 32'h0000_0005);
    rd_chk("R1 bus", 12'h008, 32'h0);
    rd_chk("R1 wp polarity", 12'h0EC, 32'h0);
    rd_chk("R1 card detect", 12'h0F0, 32'h0);
    rd_chk("R1 irq status", 12'h0FC, 32'h0);
    rd_chk("R1 cap0 lo", 12'h010, 32'h01F8_0080);
    rd_chk("R1 cap0 hi", 12'h014, 32'h0000_0007);
    rd_chk("R1 maxc0", 12'h018, 32'h0);
    rd_chk("R1 cap1 lo", 12'h020, 32'h01F8_0080);
    rd_chk("R1 cap1 hi", 12'h024, 32'h0000_0007);
    rd_chk("R1 maxc1", 12'h028, 32'h0);
    b_rd_chk("R1 info one slot", 12'h000, 32'h0001_0000);
    b_rd_chk("R1 cap lo one slot", 12'h010, 32'h01E8_0080);
    b_rd_chk("R1 cap hi one slot", 12'h014, 32'h0);
    b_rd_chk("R5 absent slot cap group", 12'h020, 32'h0);
    b_rd_chk("R5 absent slot window", 12'h200, 32'h0);
    chk("R5 absent window not forwarded", 32'(b_fwd), 32'd0);

    // R2 self-clearing bit
    wr(12'h000, 32'hDEAD_BEEF);
    rd_chk("R2 info stores upper bits", 12'h000, 32'hDEAD_BEEE);
    wr(12'h000, 32'h0000_0001);
    rd_chk("R2 info bit0 only", 12'h000, 32'h0);

    // R3 plain words
    wr(12'h004, 32'h0000_0033);
    wr(12'h008, 32'h1234_5678);
    wr(12'h0EC, 32'hA5A5_A5A5);
    wr(12'h0F0, 32'h0F0F_0F0F);
    rd_chk("R3 debounce", 12'h004, 32'h0000_0033);
    rd_chk("R3 bus", 12'h008, 32'h1234_5678);
    rd_chk("R3 wp polarity", 12'h0EC, 32'hA5A5_A5A5);
    rd_chk("R3 card detect", 12'h0F0, 32'h0F0F_0F0F);

    // R4 half-word independence
    wr(12'h014, 32'hCAFE_0001);
    rd_chk("R4 cap0 hi written", 12'h014, 32'hCAFE_0001);
    rd_chk("R4 cap0 lo kept", 12'h010, 32'h01F8_0080);
    wr(12'h020, 32'h1111_2222);
    rd_chk("R4 cap1 lo written", 12'h020, 32'h1111_2222);
    rd_chk("R4 cap1 hi kept", 12'h024, 32'h0000_0007);
    rd_chk("R4 cap0 lo other slot", 12'h010, 32'h01F8_0080);
    wr(12'h028, 32'h0000_003C);
    rd_chk("R4 maxc1", 12'h028, 32'h0000_003C);
    rd_chk("R4 maxc0 kept", 12'h018, 32'h0);

    // R5 unmapped
    hits0 = s_hits[0]; hits1 = s_hits[1];
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk("R5 unmapped 0x00C", 12'h00C, 32'h0);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd_chk("R5 unmapped 0x01C", 12'h01C, 32'h0);
    rd_chk("R5 unmapped 0x030", 12'h030, 32'h0);
    wr(12'h300, 32'h1);
    rd_chk("R5 window beyond slots", 12'h300, 32'h0);
    chk("R5 no forward", 32'(s_hits[0] + s_hits[1]), 32'(hits0 + hits1));

    // R6 invalid access forms
    xfer(1'b1, 12'h008, 32'h0, 4'b0011, rd, lat);
    rd_chk("R6 partial write ignored", 12'h008, 32'h1234_5678);
    xfer(1'b0, 12'h008, 32'h0, 4'b0011, rd, lat);
    chk("R6 partial read zero", rd, 32'h0);
    xfer(1'b0, 12'h00A, 32'h0, 4'hF, rd, lat);
    chk("R6 misaligned read zero", rd, 32'h0);
    xfer(1'b0, 12'h104, 32'h0, 4'b0001, rd, lat);
    chk("R6 partial window read local", {rd[31:1], 1'b0} | 32'(lat - 1), 32'h0);
    chk("R6 not forwarded", 32'(s_hits[0]), 32'(hits0));

    // R9 latency and single pulse
    xfer(1'b0, 12'h004, 32'h0, 4'hF, rd, lat);
    chk("R9 one-cycle latency", 32'(lat), 32'd1);
    @(negedge clk); #2;
    chk("R9 single pulse", {31'b0, rsp_valid}, 32'd0);

    // R7 / R8 interrupts
    @(negedge clk); slot_irq = 2'b10;
    repeat (2) @(negedge clk);
    #2; chk("R8 irq_out set", {31'b0, irq_out}, 32'd1);
    rd_chk("R7 status bit1", 12'h0FC, 32'h2);
    wr(12'h0FC, 32'h0);
    rd_chk("R7 status write ignored", 12'h0FC, 32'h2);
    @(negedge clk); slot_irq = 2'b11;
    repeat (2) @(negedge clk);
    rd_chk("R7 both bits", 12'h0FC, 32'h3);
    @(negedge clk); slot_irq = 2'b01;
    repeat (2) @(negedge clk);
    rd_chk("R7 bit1 cleared", 12'h0FC, 32'h1);
    @(negedge clk); slot_irq = 2'b00;
    repeat (2) @(negedge clk);
    #2; chk("R8 irq_out clear", {31'b0, irq_out}, 32'd0);
    rd_chk("R7 all clear", 12'h0FC, 32'h0);

    // R10 forwarding with backpressure
    @(negedge clk);
    s_ready[0] = 1'b0;
    req_valid = 1; req_write = 1; req_addr = 12'h104; req_wdata = 32'h0000_0077; req_strb = 4'hF;
    #2;
    chk("R10 ready follows slot", {31'b0, req_ready}, 32'd0);
    chk("R10 slot0 valid", 32'(slot_req_valid), 32'd1);
    chk("R10 slot addr offset", 32'(slot_req_addr), 32'h04);
    @(negedge clk); s_ready[0] = 1'b1; #2;
    chk("R10 ready when slot ready", {31'b0, req_ready}, 32'd1);
    @(negedge clk); req_valid = 0; #2; lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); #2; lat++; end
    chk("R10 slot response data", rsp_rdata, 32'h5A00_0004);
    chk("R10 slot saw write", {31'b0, s_wr[0]}, 32'd1);
    chk("R10 slot saw data", s_wd[0], 32'h0000_0077);
    xfer(1'b0, 12'h2F0, 32'h0, 4'hF, rd, lat);
    chk("R10 slot1 read", rd, 32'h5A01_00F0);
    chk("R10 slot1 offset", 32'(s_addr[1]), 32'hF0);

    // R11 single outstanding
    s_lat = 4;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 12'h210; req_strb = 4'hF;
    #2;
    @(negedge clk);
    req_addr = 12'h008;
    #2;
    chk("R11 local blocked while pending", {31'b0, req_ready}, 32'd0);
    lat = 0;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk); #2; lat++;
      chk("R11 ready low while pending", {31'b0, req_ready}, 32'd0);
    end
    chk("R11 slot1 answer", rsp_rdata, 32'h5A01_0010);
    @(negedge clk); req_valid = 0;
    s_lat = 3;
    rd_chk("R11 local after release", 12'h008, 32'h1234_5678);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule